// File: doc/BRIEF.md
# Three-Table Configurable Logic Block

This block is a coarse-grain programmable logic cell. Two 4-input look-up tables, called F and G, each evaluate an arbitrary function of their own four inputs. A third, 3-input table called H takes the F result, the G result and one extra input. With H it can merge F and G into any function of five variables, or into certain functions of all nine inputs, such as a wide AND, OR or XOR. Two flip-flops can capture any of the three table results. Each of the two block outputs shows either a table result picked by configuration or its own flip-flop.

The whole function comes from a 50-bit configuration word. It is shifted in serially, one bit per clock, while the configuration enable is high. Once the enable drops, the word is held and the cell runs as a fixed circuit. The configuration word and the flip-flops clear on the asynchronous reset. The flip-flops also have a synchronous clear and a clock enable.

Top module: `clb_lut3`

## Requirements
- R1: After the asynchronous reset, with nothing loaded, both outputs are 0 for every input pattern.
- R2: While cfg_en_i is high, each rising clock edge shifts cfg_din_i into bit 0 of the configuration word and moves every bit up by one. After 50 shifts, the first bit sent sits in bit 49. The layout is: [15:0] F table, [31:16] G table, [39:32] H table, [41:40] x table source, [43:42] y table source, [45:44] x flip-flop source, [47:46] y flip-flop source, [48] x registered, [49] y registered. Bits shifted in before the last 50 are lost.
- R3: While cfg_en_i is low, the configuration word does not change, whatever cfg_din_i does.
- R4: The F result is F-table bit number f_i.
- R5: The G result is G-table bit number g_i, independent of F.
- R6: The H result is H-table bit number {h1_i, G result, F result}, with the F result in the least significant position.
- R7: If the H table is 8'hCA (select G when h1_i is 1, F when it is 0) and g_i equals f_i, x shows bit {h1_i, f_i} of the 32-bit value {G table, F table}.
- R8: The tables 16'h8000/16'h8000/8'h80, 16'hFFFE/16'hFFFE/8'hFE and 16'h6996/16'h6996/8'h96 give the AND, OR and XOR of all nine inputs.
- R9: A source field picks F for 0, G for 1, and H for 2 or 3. When the registered bit of an output is 0, that output shows the selected table result combinationally.
- R10: When the registered bit is 1, the output shows its flip-flop. With cfg_en_i low, srst_i low and ce_i high, the flip-flop loads its selected source on the rising edge.
- R11: With cfg_en_i low, srst_i high clears the flip-flops on the rising edge, even if ce_i is high.
- R12: With cfg_en_i, srst_i and ce_i all low, the flip-flops keep their value.
- R13: While cfg_en_i is high, the flip-flops keep their value regardless of srst_i and ce_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_din_i | input | 1 | Serial configuration data |
| ce_i | input | 1 | Flip-flop clock enable |
| srst_i | input | 1 | Flip-flop synchronous clear |
| f_i | input | 4 | F table address |
| g_i | input | 4 | G table address |
| h1_i | input | 1 | Extra H table input |
| x_o | output | 1 | First block output |
| y_o | output | 1 | Second block output |

## Verification
Two things can land on the same edge: a flip-flop update request (ce_i, srst_i) and a configuration shift. Both can also land together with a clear and a load. The bench first sets a flip-flop to 1. It then reloads the configuration with ce_i and srst_i both held high, and after the load it reads the flip-flop back through the registered output path, expecting the 1 to survive. A separate edge raises srst_i and ce_i together with a source that reads 1, and expects 0. The table functions themselves are swept over all 512 combinations of f_i, g_i and h1_i against values the bench computes from the tables.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int F_IN   = 4;
  localparam int G_IN   = 4;
  localparam int H_IN   = 3;
  localparam int F_BITS = 1 << F_IN;
  localparam int G_BITS = 1 << G_IN;
  localparam int H_BITS = 1 << H_IN;
  localparam int N_OUT  = 2;
  localparam int N_SRC  = 3;

  typedef enum logic [1:0] {
    SRC_F  = 2'd0,
    SRC_G  = 2'd1,
    SRC_H  = 2'd2,
    SRC_H2 = 2'd3
  } src_e;

  // packed: first member is the most significant field
  typedef struct packed {
    logic              y_reg;
    logic              x_reg;
    src_e              y_ff;
    src_e              x_ff;
    src_e              y_comb;
    src_e              x_comb;
    logic [H_BITS-1:0] h_tab;
    logic [G_BITS-1:0] g_tab;
    logic [F_BITS-1:0] f_tab;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int N = 4
) (
  input  logic [(1<<N)-1:0] tab_i,
  input  logic [N-1:0]      sel_i,
  output logic              o
);
  localparam int SZ = 1 << N;

  // heap-ordered mux tree: root at 0, leaves at SZ-1..2*SZ-2
  logic [2*SZ-2:0] node;

  for (genvar k = 0; k < SZ; k++) begin : g_leaf
    assign node[SZ-1+k] = tab_i[k];
  end

  for (genvar i = 0; i < SZ-1; i++) begin : g_mux
    localparam int LVL = $clog2(i+2) - 1;
    assign node[i] = sel_i[N-1-LVL] ? node[2*i+2] : node[2*i+1];
  end

  assign o = node[0];
endmodule

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int W = 50
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_en_i,
  input  logic         cfg_din_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (cfg_en_i) sr_q <= {sr_q[W-2:0], cfg_din_i};
  end

  assign cfg_o = sr_q;

  AST_CFG_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_o[0] == $past(cfg_din_i)); // R2
  AST_CFG_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_o[W-1:1] == $past(cfg_o[W-2:0])); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_o)); // R3
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage
  import clb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             srst_i,
  input  logic             ce_i,
  input  logic [N_SRC-1:0] lut_i,   // {H, G, F}
  input  src_e             comb_sel_i,
  input  src_e             ff_sel_i,
  input  logic             reg_sel_i,
  output logic             o
);
  logic comb_val, ff_d, ff_q;

  function automatic logic pick(input src_e s, input logic [N_SRC-1:0] v);
    case (s)
      SRC_F:   return v[0];
      SRC_G:   return v[1];
      default: return v[2];
    endcase
  endfunction

  assign comb_val = pick(comb_sel_i, lut_i);
  assign ff_d     = pick(ff_sel_i, lut_i);

  // configuration freezes the register; clear beats load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ff_q <= 1'b0;
    else if (cfg_en_i) ff_q <= ff_q;
    else if (srst_i)   ff_q <= 1'b0;
    else if (ce_i)     ff_q <= ff_d;
  end

  assign o = reg_sel_i ? ff_q : comb_val;

  AST_FF_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> $stable(ff_q)); // R13
  AST_FF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && srst_i) |=> !ff_q); // R11
  AST_FF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && !srst_i && !ce_i) |=> $stable(ff_q)); // R12
  AST_FF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && !srst_i && ce_i) |=> ff_q == $past(ff_d)); // R10
endmodule

// File: rtl/clb_lut3.sv
module clb_lut3
  import clb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_en_i,
  input  logic            cfg_din_i,
  input  logic            ce_i,
  input  logic            srst_i,
  input  logic [F_IN-1:0] f_i,
  input  logic [G_IN-1:0] g_i,
  input  logic            h1_i,
  output logic            x_o,
  output logic            y_o
);
  logic [CFG_W-1:0] cfg_vec;
  cfg_t             cfg;
  logic             f_val, g_val, h_val;
  logic [N_SRC-1:0] lut_vals;
  src_e             comb_sel [N_OUT];
  src_e             ff_sel   [N_OUT];
  logic [N_OUT-1:0] reg_sel, outs;

  clb_cfg_chain #(.W(CFG_W)) i_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .cfg_din_i (cfg_din_i),
    .cfg_o     (cfg_vec)
  );
  assign cfg = cfg_t'(cfg_vec);

  clb_lut #(.N(F_IN)) i_lut_f (.tab_i(cfg.f_tab), .sel_i(f_i), .o(f_val));
  clb_lut #(.N(G_IN)) i_lut_g (.tab_i(cfg.g_tab), .sel_i(g_i), .o(g_val));
  clb_lut #(.N(H_IN)) i_lut_h (.tab_i(cfg.h_tab), .sel_i({h1_i, g_val, f_val}), .o(h_val));

  assign lut_vals = {h_val, g_val, f_val};

  assign comb_sel[0] = cfg.x_comb;
  assign comb_sel[1] = cfg.y_comb;
  assign ff_sel[0]   = cfg.x_ff;
  assign ff_sel[1]   = cfg.y_ff;
  assign reg_sel     = {cfg.y_reg, cfg.x_reg};

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    clb_out_stage i_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_en_i   (cfg_en_i),
      .srst_i     (srst_i),
      .ce_i       (ce_i),
      .lut_i      (lut_vals),
      .comb_sel_i (comb_sel[o]),
      .ff_sel_i   (ff_sel[o]),
      .reg_sel_i  (reg_sel[o]),
      .o          (outs[o])
    );
  end

  assign x_o = outs[0];
  assign y_o = outs[1];

  AST_F_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_val == cfg.f_tab[f_i]); // R4
  AST_G_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_val == cfg.g_tab[g_i]); // R5
  AST_H_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_val == cfg.h_tab[{h1_i, g_val, f_val}]); // R6
endmodule

// File: tb/test_clb_lut3.sv
module test_clb_lut3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_din = 1'b0, ce = 1'b0, srst = 1'b0, h1 = 1'b0;
  logic [3:0] f = '0, g = '0;
  logic x, y;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  clb_lut3 i_clb_lut3 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_din_i(cfg_din),
    .ce_i(ce), .srst_i(srst), .f_i(f), .g_i(g), .h1_i(h1), .x_o(x), .y_o(y)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (f=%h g=%h h1=%b)", req, act, exp, f, g, h1);
    end
  endtask

  function automatic logic [49:0] mk(input logic [15:0] ft, input logic [15:0] gt,
      input logic [7:0] ht, input logic [1:0] xc, input logic [1:0] yc,
      input logic [1:0] xf, input logic [1:0] yf, input logic xr, input logic yr);
    return {yr, xr, yf, xf, yc, xc, ht, gt, ft};
  endfunction

  function automatic logic sel_val(input logic [1:0] s, input logic fo, input logic go, input logic ho);
    return (s == 2'd0) ? fo : (s == 2'd1) ? go : ho;
  endfunction

  task automatic load(input logic [49:0] w);
    for (int i = 49; i >= 0; i--) begin
      cfg_en = 1'b1; cfg_din = w[i];
      @(posedge clk); #2;
    end
    cfg_en = 1'b0; cfg_din = 1'b0;
  endtask

  // exhaustive combinational sweep against table arithmetic
  task automatic sweep(input logic [15:0] ft, input logic [15:0] gt, input logic [7:0] ht,
      input logic [1:0] xc, input logic [1:0] yc, input string rx, input string ry);
    for (int a = 0; a < 512; a++) begin
      logic fo, go, ho;
      f = a[3:0]; g = a[7:4]; h1 = a[8];
      #1;
      fo = ft[f]; go = gt[g]; ho = ht[{h1, go, fo}];
      chk(rx, x, sel_val(xc, fo, go, ho));
      chk(ry, y, sel_val(yc, fo, go, ho));
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: cleared configuration gives zeros
    for (int a = 0; a < 512; a += 37) begin
      f = a[3:0]; g = a[7:4]; h1 = a[8]; #1;
      chk("R1", x, 1'b0); chk("R1", y, 1'b0);
    end

    // R6 / R5: x from H, y from G
    load(mk(16'h6996, 16'h8000, 8'hE8, 2'd2, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0));
    sweep(16'h6996, 16'h8000, 8'hE8, 2'd2, 2'd1, "R6", "R5");

    // R3: configuration data ignored while enable low
    for (int i = 0; i < 20; i++) begin
      cfg_din = i[0]; @(posedge clk); #2;
    end
    sweep(16'h6996, 16'h8000, 8'hE8, 2'd2, 2'd1, "R3", "R3");

    // R4 / R9: x from F, y from H via code 3
    load(mk(16'hA5C3, 16'h1234, 8'h5A, 2'd0, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0));
    sweep(16'hA5C3, 16'h1234, 8'h5A, 2'd0, 2'd3, "R4", "R9");

    // R2: a leading extra bit falls off the chain; x from G, y from F
    cfg_en = 1'b1; cfg_din = 1'b1; @(posedge clk); #2;
    load(mk(16'h0F1E, 16'hC0DE, 8'h3C, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
    sweep(16'h0F1E, 16'hC0DE, 8'h3C, 2'd1, 2'd0, "R2", "R9");

    // R7: five-input function, G mirrors F inputs
    load(mk(16'hBEEF, 16'hDEAD, 8'hCA, 2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0));
    for (int a = 0; a < 32; a++) begin
      logic [31:0] t5;
      t5 = 32'hDEADBEEF;
      f = a[3:0]; g = a[3:0]; h1 = a[4]; #1;
      chk("R7", x, t5[{h1, f}]);
    end

    // R8: nine-input AND, OR, XOR
    for (int k = 0; k < 3; k++) begin
      logic [15:0] t;
      logic [7:0] ht;
      t  = (k == 0) ? 16'h8000 : (k == 1) ? 16'hFFFE : 16'h6996;
      ht = (k == 0) ? 8'h80    : (k == 1) ? 8'hFE    : 8'h96;
      load(mk(t, t, ht, 2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0));
      for (int a = 0; a < 512; a++) begin
        logic [8:0] v;
        logic e;
        v = a[8:0];
        f = v[3:0]; g = v[7:4]; h1 = v[8]; #1;
        e = (k == 0) ? &v : (k == 1) ? |v : ^v;
        chk("R8", x, e);
      end
    end

    // R10: x registers F, y registers H
    load(mk(16'h6996, 16'h8000, 8'hE8, 2'd0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1));
    ce = 1'b1;
    for (int a = 0; a < 40; a++) begin
      logic ef, eh, go;
      f = a[3:0]; g = 4'(a * 7); h1 = a[2];
      ef = 16'h6996 >> f;
      go = g == 4'hF;
      eh = 8'hE8 >> {h1, go, ef};
      @(posedge clk); #2;
      chk("R10", x, ef); chk("R10", y, eh);
    end

    // R12: enable low holds
    f = 4'h1; @(posedge clk); #2;
    chk("R10", x, 1'b1);
    ce = 1'b0; f = 4'h0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2; chk("R12", x, 1'b1);
    end

    // R11: clear wins over load of a 1
    ce = 1'b1; srst = 1'b1; f = 4'h1;
    @(posedge clk); #2;
    chk("R11", x, 1'b0);
    srst = 1'b0; @(posedge clk); #2;
    chk("R10", x, 1'b1);

    // R13: reconfigure with clear and load both requested; register must hold 1
    srst = 1'b1; ce = 1'b1; f = 4'h0;
    load(mk(16'h6996, 16'h8000, 8'hE8, 2'd0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1));
    ce = 1'b0; srst = 1'b0; #1;
    chk("R13", x, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule